// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block listens to an I2C bus without taking part in it. It takes SCL and SDA after they have been synchronized into the system clock domain. It finds Start and Stop conditions and keeps a flag that shows whether a transfer is in progress. It assembles every byte that passes on the wire into a one-entry holding register. The bit after each byte is kept as the acknowledge level. The block does not decode addresses and does not interpret transfers; it records raw bytes only.

Software, or a consuming block, reads bytes through a read strobe. Write-one-to-clear strobes reset the overrun flag and the idle-event flag. When clock stretching is enabled, the monitor asks for SCL to be held low while an unread byte sits in the register, so no byte is lost. When stretching is disabled, a byte that arrives before the previous one was read replaces it, and the overrun flag records the loss. An interrupt output follows the idle-event flag, gated by an enable input.

Top module: `i2c_bus_watch`

## Requirements
- R1: After synchronous reset, data_rdy, ovf_flag, bus_active, idle_flag, idle_irq and scl_hold are all 0.
- R2: bus_active goes to 1 when a Start is seen (SDA falls while SCL stays high). It goes to 0 when a Stop is seen (SDA rises while SCL stays high). The flag therefore shows whether a Start came later than the last Stop.
- R3: A byte completes on the 8th SCL rising edge after a Start, or after the previous acknowledge bit. Bits are taken most significant first. The byte is placed in rx_byte and data_rdy is set.
- R4: The level of SDA on the 9th SCL rising edge of each byte is stored in rx_ack (0 = acknowledged, 1 = not acknowledged).
- R5: A pulse on rd_strobe clears data_rdy when no byte completes in the same cycle.
- R6: idle_flag sets when bus_active goes from 1 to 0. idle_irq equals idle_flag ANDed with idle_irq_en.
- R7: idle_flag stays set until clr_idle is pulsed. If a new idle event falls in the same cycle as clr_idle, the flag stays set.
- R8: With stretch_en at 0, a byte that completes while data_rdy is still set sets ovf_flag, and the new byte overwrites rx_byte.
- R9: With stretch_en at 1, ovf_flag never sets. scl_hold goes to 1 once SCL is low while a byte is unread, and returns to 0 after the byte is read.
- R10: A pulse on clr_ovf clears ovf_flag.
- R11: A read strobe in the same cycle as a byte completion leaves data_rdy at 1 and rx_byte holding the new byte, and it does not set ovf_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| rd_strobe | input | 1 | One-cycle read of the holding register |
| clr_ovf | input | 1 | Write-one-to-clear for ovf_flag |
| clr_idle | input | 1 | Write-one-to-clear for idle_flag |
| stretch_en | input | 1 | Enables SCL stretching while a byte is unread |
| idle_irq_en | input | 1 | Enables the idle interrupt |
| rx_byte | output | DW | Last captured byte |
| rx_ack | output | 1 | Acknowledge level of the last byte |
| data_rdy | output | 1 | An unread byte is held |
| ovf_flag | output | 1 | A byte was overwritten before it was read |
| bus_active | output | 1 | Bus is inside a Start..Stop frame |
| idle_flag | output | 1 | Bus went from active to inactive |
| idle_irq | output | 1 | Idle interrupt request |
| scl_hold | output | 1 | Request to pull SCL low |

## Verification
Two events can fall in the same cycle, and each collision is checked. The first is a read of the holding register in the cycle where a new byte completes. The bench makes this happen by pulsing the read strobe on the clock edge just after the eighth SCL rise, with an unread byte already held. The data-ready flag must stay set, the new byte must appear, and no overrun may be recorded. The second collision is a clear of the idle flag in the same cycle that a Stop is detected; the bench drives the SDA rise and the clear strobe on the same edge, and the idle flag must remain set.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  // One-cycle bus events decoded from the sampled SCL/SDA pair
  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
  } bus_evt_t;
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond
  import i2c_mon_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     scl_i,
  input  logic     sda_i,
  input  logic     clr_idle,
  input  logic     idle_irq_en,
  output bus_evt_t evt,
  output logic     active,
  output logic     idle_flag,
  output logic     idle_irq
);
  logic scl_q, sda_q;
  logic active_n, idle_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    evt.start    = scl_q & scl_i & sda_q & ~sda_i;
    evt.stop     = scl_q & scl_i & ~sda_q & sda_i;
    evt.scl_rise = ~scl_q & scl_i;
  end

  always_comb begin
    active_n = active;
    if (evt.start)     active_n = 1'b1;
    else if (evt.stop) active_n = 1'b0;
    // a new idle event takes priority over a clear in the same cycle
    idle_n = idle_flag;
    if (active & evt.stop) idle_n = 1'b1;
    else if (clr_idle)     idle_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      idle_flag <= 1'b0;
      idle_irq  <= 1'b0;
    end else begin
      active    <= active_n;
      idle_flag <= idle_n;
      idle_irq  <= idle_n & idle_irq_en;
    end
  end
endmodule

// File: rtl/i2c_bit_shift.sv
module i2c_bit_shift
  import i2c_mon_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  bus_evt_t      evt,
  input  logic          active,
  input  logic          sda_i,
  output logic [DW-1:0] byte_q,
  output logic          done,
  output logic          ack
);
  localparam int            CW   = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);
  localparam logic [CW-1:0] FULL = CW'(DW);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      byte_q <= '0;
      done   <= 1'b0;
      ack    <= 1'b1;
    end else begin
      done <= 1'b0;
      if (evt.start || evt.stop) begin
        cnt <= '0;
      end else if (evt.scl_rise && active) begin
        if (cnt == FULL) begin
          ack <= sda_i;
          cnt <= '0;
        end else begin
          byte_q <= {byte_q[DW-2:0], sda_i};
          cnt    <= cnt + 1'b1;
          if (cnt == LAST) done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_mon_hold.sv
module i2c_mon_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done,
  input  logic [DW-1:0] byte_in,
  input  logic          rd_strobe,
  input  logic          clr_ovf,
  input  logic          stretch_en,
  input  logic          scl_i,
  output logic [DW-1:0] rx_byte,
  output logic          data_rdy,
  output logic          ovf_flag,
  output logic          scl_hold
);
  logic rdy_n, ovf_n, hold_n;

  always_comb begin
    rdy_n = data_rdy;
    if (done)           rdy_n = 1'b1;
    else if (rd_strobe) rdy_n = 1'b0;
    ovf_n = ovf_flag;
    if (done && data_rdy && !rd_strobe && !stretch_en) ovf_n = 1'b1;
    else if (clr_ovf)                                  ovf_n = 1'b0;
    // only start pulling once SCL is already low, then keep it
    hold_n = stretch_en & rdy_n & (scl_hold | ~scl_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte  <= '0;
      data_rdy <= 1'b0;
      ovf_flag <= 1'b0;
      scl_hold <= 1'b0;
    end else begin
      if (done) rx_byte <= byte_in;
      data_rdy <= rdy_n;
      ovf_flag <= ovf_n;
      scl_hold <= hold_n;
    end
  end
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
  import i2c_mon_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          rd_strobe,
  input  logic          clr_ovf,
  input  logic          clr_idle,
  input  logic          stretch_en,
  input  logic          idle_irq_en,
  output logic [DW-1:0] rx_byte,
  output logic          rx_ack,
  output logic          data_rdy,
  output logic          ovf_flag,
  output logic          bus_active,
  output logic          idle_flag,
  output logic          idle_irq,
  output logic          scl_hold
);
  bus_evt_t      evt;
  logic [DW-1:0] shift_byte;
  logic          byte_done;

  i2c_bus_cond u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .clr_idle(clr_idle), .idle_irq_en(idle_irq_en),
    .evt(evt), .active(bus_active), .idle_flag(idle_flag), .idle_irq(idle_irq)
  );

  i2c_bit_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .evt(evt), .active(bus_active), .sda_i(sda_i),
    .byte_q(shift_byte), .done(byte_done), .ack(rx_ack)
  );

  i2c_mon_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .done(byte_done), .byte_in(shift_byte),
    .rd_strobe(rd_strobe), .clr_ovf(clr_ovf), .stretch_en(stretch_en),
    .scl_i(scl_i), .rx_byte(rx_byte), .data_rdy(data_rdy),
    .ovf_flag(ovf_flag), .scl_hold(scl_hold)
  );
endmodule

// File: rtl/i2c_bus_watch_chk.sv
module i2c_bus_watch_chk (
  input logic clk,
  input logic rst,
  input logic rd_strobe,
  input logic stretch_en,
  input logic data_rdy,
  input logic ovf_flag,
  input logic bus_active,
  input logic idle_flag,
  input logic scl_hold,
  input logic done
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!data_rdy && !ovf_flag && !bus_active && !idle_flag && !scl_hold));
  // R3
  done_sets_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> data_rdy);
  // R5
  read_clears_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !done) |=> !data_rdy);
  // R6
  idle_on_deact_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(idle_flag) |-> $fell(bus_active));
  // R9
  no_ovf_stretch_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> $past(!stretch_en));
  // R9
  hold_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    scl_hold |-> (data_rdy && $past(stretch_en)));
endmodule

bind i2c_bus_watch i2c_bus_watch_chk u_chk (
  .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .stretch_en(stretch_en),
  .data_rdy(data_rdy), .ovf_flag(ovf_flag), .bus_active(bus_active),
  .idle_flag(idle_flag), .scl_hold(scl_hold), .done(byte_done)
);

// File: tb/i2c_bus_watch_tb.sv
module i2c_bus_watch_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda = 1'b1;
  logic mon_rd = 1'b0, man_rd = 1'b0;
  logic clr_ovf = 1'b0, clr_idle = 1'b0, stretch_en = 1'b0, irq_en = 1'b0;
  logic auto_rd = 1'b0;
  logic [7:0] rx_byte;
  logic rx_ack, data_rdy, ovf_flag, bus_active, idle_flag, idle_irq, scl_hold;
  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  i2c_bus_watch u_dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .rd_strobe(mon_rd | man_rd),
    .clr_ovf(clr_ovf), .clr_idle(clr_idle), .stretch_en(stretch_en),
    .idle_irq_en(irq_en), .rx_byte(rx_byte), .rx_ack(rx_ack), .data_rdy(data_rdy),
    .ovf_flag(ovf_flag), .bus_active(bus_active), .idle_flag(idle_flag),
    .idle_irq(idle_irq), .scl_hold(scl_hold)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    @(negedge clk); sda = b;
    wait_n(2); scl = 1'b1;
    wait_n(4); scl = 1'b0;
    wait_n(2);
  endtask

  task automatic do_start();
    @(negedge clk); sda = 1'b1;
    wait_n(2); scl = 1'b1;
    wait_n(2); sda = 1'b0;
    wait_n(2); scl = 1'b0;
    wait_n(2);
  endtask

  task automatic do_stop(input logic with_clr);
    @(negedge clk); sda = 1'b0;
    wait_n(2); scl = 1'b1;
    wait_n(2); sda = 1'b1; clr_idle = with_clr;
    @(negedge clk); clr_idle = 1'b0;
    wait_n(4);
  endtask

  // driver: sends a byte plus acknowledge bit, queues expected value
  task automatic send_byte(input logic [7:0] v, input logic a, input logic push);
    if (push) exp_q.push_back(v);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    put_bit(a);
  endtask

  task automatic pulse_rd();
    @(negedge clk); man_rd = 1'b1;
    @(negedge clk); man_rd = 1'b0;
    wait_n(1);
  endtask

  // monitor: pops the scoreboard whenever a byte is ready
  initial begin
    forever begin
      @(negedge clk);
      if (mon_rd) mon_rd = 1'b0;
      else if (!rst && auto_rd && data_rdy) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected byte", rx_byte, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_byte == e, "R3 captured byte", rx_byte, e);
        end
        mon_rd = 1'b1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait_n(5); rst = 1'b0; wait_n(2);
    // R1
    chk({data_rdy, ovf_flag, bus_active, idle_flag, idle_irq, scl_hold} == 6'b0,
        "R1 reset flags", {data_rdy, ovf_flag, bus_active, idle_flag, idle_irq, scl_hold}, 0);

    auto_rd = 1'b1; irq_en = 1'b1;
    do_start();
    chk(bus_active == 1'b1, "R2 active after start", bus_active, 1);
    send_byte(8'hA5, 1'b0, 1'b1);
    chk(rx_ack == 1'b0, "R4 ack low", rx_ack, 0);
    send_byte(8'h00, 1'b1, 1'b1);
    chk(rx_ack == 1'b1, "R4 nack high", rx_ack, 1);
    send_byte(8'hFF, 1'b0, 1'b1);
    send_byte(8'h3C, 1'b0, 1'b1);
    wait_n(4);
    chk(data_rdy == 1'b0, "R5 read clears ready", data_rdy, 0);
    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    chk(idle_flag == 1'b0, "R6 no idle while active", idle_flag, 0);
    do_stop(1'b0);
    chk(bus_active == 1'b0, "R2 inactive after stop", bus_active, 0);
    chk(idle_flag == 1'b1, "R6 idle set on stop", idle_flag, 1);
    chk(idle_irq == 1'b1, "R6 irq when enabled", idle_irq, 1);
    wait_n(10);
    chk(idle_flag == 1'b1, "R7 idle held", idle_flag, 1);
    @(negedge clk); clr_idle = 1'b1;
    @(negedge clk); clr_idle = 1'b0;
    chk(idle_flag == 1'b0, "R7 idle cleared", idle_flag, 0);
    chk(idle_irq == 1'b0, "R6 irq follows clear", idle_irq, 0);

    irq_en = 1'b0;
    do_start();
    do_stop(1'b1);
    chk(idle_flag == 1'b1, "R7 set wins over clear", idle_flag, 1);
    chk(idle_irq == 1'b0, "R6 irq masked", idle_irq, 0);
    @(negedge clk); clr_idle = 1'b1;
    @(negedge clk); clr_idle = 1'b0;

    // overrun with stretching disabled
    auto_rd = 1'b0;
    do_start();
    send_byte(8'h12, 1'b0, 1'b0);
    chk(data_rdy == 1'b1 && rx_byte == 8'h12, "R3 byte held", rx_byte, 8'h12);
    chk(ovf_flag == 1'b0, "R8 no overrun yet", ovf_flag, 0);
    send_byte(8'h34, 1'b0, 1'b0);
    chk(ovf_flag == 1'b1, "R8 overrun set", ovf_flag, 1);
    chk(rx_byte == 8'h34, "R8 overwrite", rx_byte, 8'h34);
    chk(scl_hold == 1'b0, "R9 no hold when disabled", scl_hold, 0);
    @(negedge clk); clr_ovf = 1'b1;
    @(negedge clk); clr_ovf = 1'b0;
    chk(ovf_flag == 1'b0, "R10 overrun cleared", ovf_flag, 0);

    // R11: read collides with completion of 0x56
    for (int i = 7; i >= 1; i--) put_bit(((8'h56 >> i) & 8'h01) != 0);
    @(negedge clk); sda = 1'b0;
    wait_n(2); scl = 1'b1;
    @(negedge clk); man_rd = 1'b1;
    @(negedge clk); man_rd = 1'b0;
    wait_n(2); scl = 1'b0;
    wait_n(2);
    chk(data_rdy == 1'b1, "R11 ready kept", data_rdy, 1);
    chk(rx_byte == 8'h56, "R11 new byte", rx_byte, 8'h56);
    chk(ovf_flag == 1'b0, "R11 no overrun", ovf_flag, 0);
    put_bit(1'b0);
    pulse_rd();
    chk(data_rdy == 1'b0, "R5 manual read", data_rdy, 0);

    // stretching
    stretch_en = 1'b1;
    for (int i = 7; i >= 0; i--) put_bit(((8'h78 >> i) & 8'h01) != 0);
    chk(scl_hold == 1'b1, "R9 hold while unread", scl_hold, 1);
    pulse_rd();
    chk(scl_hold == 1'b0, "R9 released after read", scl_hold, 0);
    chk(rx_byte == 8'h78, "R3 stretched byte", rx_byte, 8'h78);
    put_bit(1'b0);
    send_byte(8'h9A, 1'b0, 1'b0);
    send_byte(8'hBC, 1'b0, 1'b0);
    chk(ovf_flag == 1'b0, "R9 no overrun with stretch", ovf_flag, 0);
    chk(rx_byte == 8'hBC, "R9 latest byte", rx_byte, 8'hBC);
    pulse_rd();
    stretch_en = 1'b0;
    do_stop(1'b0);
    chk(bus_active == 1'b0, "R2 final stop", bus_active, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule